// File: doc/BRIEF.md
# Counter Clock and Gate Routing Fabric

This block sits in front of one group of three 16-bit counter channels and decides, per channel, what drives the counter's clock and what drives its gate. Each channel holds a clock-select code and a gate-select code. A small write port loads these codes. The block then routes the chosen signals to the counter. The candidates are:

- the channel's own pins and a clock pin shared by the group;
- a chain of divided timebases derived from the 20 MHz system clock;
- fixed levels;
- neighbouring counter outputs;
- pattern-match status.

Groups are chained in a ring. Channel 0 takes its "preceding" clock from the last channel of the previous group. Channels 0 and 1 take their "two back" gate from that same group.

Timebases are single-cycle enable pulses in the system clock domain, so a counter sees a selected clock as a one-cycle-high enable. Two pattern latches also feed the gate selection: one records that a pattern occurred, and one records that it went away afterwards. The block also derives the direction of each clock and gate pin from the codes. Parameter `ENHANCED` selects the 5-bit code set; with it cleared, only 3-bit codes exist and the extended gate codes read low.

Top module: `ctr_route`

## Requirements
- R1: After reset every channel has clock code 0 and gate code 0. So clk_o follows clk_pin_i, gate_o is 1, clock pins are inputs (clk_pin_oe_o=0) and gate pins are outputs (gat_pin_oe_o=1).
- R2: Clock code 0 routes the channel's clk_pin_i bit, 7 routes ext_clk_i, 8 routes constant 1 and 9 routes constant 0.
- R3: Clock codes 1, 2, 3, 4, 5 and 11 route enable pulses that are high for one system cycle out of every 2, 20, 200, 2000, 20000 and 1 cycles respectively (10 MHz, 1 MHz, 100 kHz, 10 kHz, 1 kHz and 20 MHz).
- R4: Clock code 6 routes the preceding output: channel 0 takes prev_out_i[2] and channel n>0 takes ctr_out_i[n-1].
- R5: Gate code 0 gives 1, code 1 gives 0, code 2 gives the channel's gat_pin_i bit and code 6 gives its inverse.
- R6: The "two back" gate source is prev_out_i[1] for channel 0, prev_out_i[2] for channel 1 and ctr_out_i[0] for channel 2. Gate code 3 routes it inverted and code 7 routes it unchanged.
- R7: Gate code 8 routes pat_present_i and gate code 11 routes its inverse. Clock code 10 also routes pat_present_i.
- R8: The occurred latch goes to 1 on the first clock edge that samples pat_present_i=1 and holds after the pattern drops. Gate code 9 routes the latch and gate code 12 routes its inverse.
- R9: The gone latch goes to 1 on the first clock edge that samples pat_present_i=0 while the occurred latch is set, and never before an occurrence. Gate code 10 routes the latch and gate code 13 routes its inverse.
- R10: A write with wr_ch_i=3 and wr_data_i[0]=1 clears both latches at that edge. The same write with wr_data_i[0]=0 leaves them unchanged.
- R11: Unused and reserved codes route constant 0. These are clock codes 12..31 and gate codes 4, 5 and 14..31.
- R12: clk_pin_oe_o of a channel is 0 only when its clock code is 0. gat_pin_oe_o is 0 only when its gate code is 2.
- R13: A write with wr_ch_i<3 loads wr_data_i into the clock code (wr_fld_i=0) or gate code (wr_fld_i=1) of that channel only. It takes effect after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 20 MHz system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the selection port |
| wr_ch_i | input | 2 | Target channel 0..2; 3 addresses the latch-clear control |
| wr_fld_i | input | 1 | 0 selects clock code, 1 selects gate code |
| wr_data_i | input | 5 | Code to load, or bit 0 = latch clear |
| clk_pin_i | input | 3 | Per-channel clock pin inputs |
| gat_pin_i | input | 3 | Per-channel gate pin inputs |
| ext_clk_i | input | 1 | Clock pin shared by the group |
| ctr_out_i | input | 3 | Outputs of this group's counters |
| prev_out_i | input | 3 | Outputs of the preceding group's counters in the ring |
| pat_present_i | input | 1 | Pattern-match present status |
| clk_o | output | 3 | Selected clock (enable) per channel, also driven to the clock pin |
| gate_o | output | 3 | Selected gate per channel, also driven to the gate pin |
| clk_pin_oe_o | output | 3 | Clock pin drive enable per channel |
| gat_pin_oe_o | output | 3 | Gate pin drive enable per channel |

## Verification
The bench goes after the ring wiring at the group edges. A fabric that indexed neighbours naively would feed channel 0 from its own group or pick the wrong "two back" channel, and the distinct prev_out_i and ctr_out_i patterns would show the swapped bit. It measures every timebase over whole periods, so an off-by-one divider gives a wrong pulse count. It walks the pattern through occur, drop and clear in order. A gone latch that set before the first occurrence, or a clear that ignored bit 0, would flip the inverted gate codes. It also checks that a write does not show before its edge and touches no other channel.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;
  localparam int N_CH   = 3;
  localparam int CODE_W = 5;
  localparam int N_TB   = 5;  // 10M, 1M, 100k, 10k, 1k

  localparam logic [CODE_W-1:0] CK_PIN  = 5'd0;
  localparam logic [CODE_W-1:0] CK_PREV = 5'd6;
  localparam logic [CODE_W-1:0] CK_EXT  = 5'd7;
  localparam logic [CODE_W-1:0] CK_HI   = 5'd8;
  localparam logic [CODE_W-1:0] CK_LO   = 5'd9;
  localparam logic [CODE_W-1:0] CK_PAT  = 5'd10;
  localparam logic [CODE_W-1:0] CK_SYS  = 5'd11;

  localparam logic [CODE_W-1:0] GT_ON    = 5'd0;
  localparam logic [CODE_W-1:0] GT_OFF   = 5'd1;
  localparam logic [CODE_W-1:0] GT_PIN   = 5'd2;
  localparam logic [CODE_W-1:0] GT_NTB   = 5'd3;
  localparam logic [CODE_W-1:0] GT_NPIN  = 5'd6;
  localparam logic [CODE_W-1:0] GT_TB    = 5'd7;
  localparam logic [CODE_W-1:0] GT_PAT   = 5'd8;
  localparam logic [CODE_W-1:0] GT_OCC   = 5'd9;
  localparam logic [CODE_W-1:0] GT_GONE  = 5'd10;
  localparam logic [CODE_W-1:0] GT_NPAT  = 5'd11;
  localparam logic [CODE_W-1:0] GT_NOCC  = 5'd12;
  localparam logic [CODE_W-1:0] GT_NGONE = 5'd13;

  localparam logic [1:0] CTRL_SLOT = 2'd3;
endpackage

// File: rtl/ctr_route_tbase.sv
module ctr_route_tbase #(
  parameter int FIRST_DIV = 2,
  parameter int STEP_DIV  = 10,
  parameter int N_OUT     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [N_OUT-1:0] tick_o
);
  localparam int FW = (FIRST_DIV > 1) ? $clog2(FIRST_DIV) : 1;
  localparam int SW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [FW-1:0] F_LAST = FW'(FIRST_DIV - 1);
  localparam logic [SW-1:0] S_LAST = SW'(STEP_DIV - 1);

  logic [FW-1:0] cnt0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt0_q <= '0;
    else if (cnt0_q == F_LAST) cnt0_q <= '0;
    else                      cnt0_q <= cnt0_q + 1'b1;
  end
  assign tick_o[0] = (cnt0_q == F_LAST);

  for (genvar g = 1; g < N_OUT; g++) begin : g_stage
    logic [SW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (tick_o[g-1]) cnt_q <= (cnt_q == S_LAST) ? '0 : cnt_q + 1'b1;
    end
    assign tick_o[g] = tick_o[g-1] && (cnt_q == S_LAST);
  end
endmodule

// File: rtl/ctr_route_patlatch.sv
module ctr_route_patlatch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pat_i,
  input  logic clr_i,
  output logic occ_o,
  output logic gone_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_o  <= 1'b0;
      gone_o <= 1'b0;
    end else if (clr_i) begin
      occ_o  <= 1'b0;
      gone_o <= 1'b0;
    end else begin
      if (pat_i)           occ_o  <= 1'b1;
      if (occ_o && !pat_i) gone_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ctr_route_chan.sv
module ctr_route_chan
  import ctr_route_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic [CODE_W-1:0] csel_i,
  input  logic [CODE_W-1:0] gsel_i,
  input  logic              clk_pin_i,
  input  logic              gat_pin_i,
  input  logic              ext_clk_i,
  input  logic [N_TB-1:0]   tb_i,
  input  logic              prev_i,
  input  logic              two_back_i,
  input  logic              pat_i,
  input  logic              occ_i,
  input  logic              gone_i,
  output logic              clk_o,
  output logic              gate_o,
  output logic              clk_oe_o,
  output logic              gat_oe_o
);
  localparam logic EN = ENHANCED;

  always_comb begin
    case (csel_i)
      CK_PIN:  clk_o = clk_pin_i;
      5'd1:    clk_o = tb_i[0];
      5'd2:    clk_o = tb_i[1];
      5'd3:    clk_o = tb_i[2];
      5'd4:    clk_o = tb_i[3];
      5'd5:    clk_o = tb_i[4];
      CK_PREV: clk_o = prev_i;
      CK_EXT:  clk_o = ext_clk_i;
      CK_HI:   clk_o = EN;
      CK_LO:   clk_o = 1'b0;
      CK_PAT:  clk_o = EN & pat_i;
      CK_SYS:  clk_o = EN;  // enable every system cycle
      default: clk_o = 1'b0;
    endcase
  end

  always_comb begin
    case (gsel_i)
      GT_ON:    gate_o = 1'b1;
      GT_OFF:   gate_o = 1'b0;
      GT_PIN:   gate_o = gat_pin_i;
      GT_NTB:   gate_o = ~two_back_i;
      GT_NPIN:  gate_o = EN & ~gat_pin_i;
      GT_TB:    gate_o = EN & two_back_i;
      GT_PAT:   gate_o = EN & pat_i;
      GT_OCC:   gate_o = EN & occ_i;
      GT_GONE:  gate_o = EN & gone_i;
      GT_NPAT:  gate_o = EN & ~pat_i;
      GT_NOCC:  gate_o = EN & ~occ_i;
      GT_NGONE: gate_o = EN & ~gone_i;
      default:  gate_o = 1'b0;
    endcase
  end

  assign clk_oe_o = (csel_i != CK_PIN);
  assign gat_oe_o = (gsel_i != GT_PIN);
endmodule

// File: rtl/ctr_route.sv
module ctr_route
  import ctr_route_pkg::*;
#(
  parameter bit ENHANCED  = 1'b1,
  parameter int FIRST_DIV = 2,
  parameter int STEP_DIV  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_ch_i,
  input  logic              wr_fld_i,
  input  logic [CODE_W-1:0] wr_data_i,
  input  logic [N_CH-1:0]   clk_pin_i,
  input  logic [N_CH-1:0]   gat_pin_i,
  input  logic              ext_clk_i,
  input  logic [N_CH-1:0]   ctr_out_i,
  input  logic [N_CH-1:0]   prev_out_i,
  input  logic              pat_present_i,
  output logic [N_CH-1:0]   clk_o,
  output logic [N_CH-1:0]   gate_o,
  output logic [N_CH-1:0]   clk_pin_oe_o,
  output logic [N_CH-1:0]   gat_pin_oe_o
);
  localparam int SEL_W = ENHANCED ? CODE_W : 3;

  logic [N_TB-1:0] tb_tick;
  logic            pat_occ, pat_gone, lat_clr;

  assign lat_clr = wr_en_i && (wr_ch_i == CTRL_SLOT) && wr_data_i[0];

  ctr_route_tbase #(
    .FIRST_DIV(FIRST_DIV), .STEP_DIV(STEP_DIV), .N_OUT(N_TB)
  ) u_tbase (
    .clk_i, .rst_ni, .tick_o(tb_tick)
  );

  ctr_route_patlatch u_pat (
    .clk_i, .rst_ni, .pat_i(pat_present_i), .clr_i(lat_clr),
    .occ_o(pat_occ), .gone_o(pat_gone)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [SEL_W-1:0] csel_q, gsel_q;
    logic             prev_src, two_back_src;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        csel_q <= '0;
        gsel_q <= '0;
      end else if (wr_en_i && wr_ch_i == 2'(c)) begin
        if (wr_fld_i) gsel_q <= wr_data_i[SEL_W-1:0];
        else          csel_q <= wr_data_i[SEL_W-1:0];
      end
    end

    // ring neighbours: preceding group feeds the low channels
    if (c == 0) begin : g_prev_ring
      assign prev_src = prev_out_i[N_CH-1];
    end else begin : g_prev_local
      assign prev_src = ctr_out_i[c-1];
    end
    if (c >= 2) begin : g_tb_local
      assign two_back_src = ctr_out_i[c-2];
    end else begin : g_tb_ring
      assign two_back_src = prev_out_i[c+N_CH-2];
    end

    ctr_route_chan #(.ENHANCED(ENHANCED)) u_chan (
      .csel_i     (CODE_W'(csel_q)),
      .gsel_i     (CODE_W'(gsel_q)),
      .clk_pin_i  (clk_pin_i[c]),
      .gat_pin_i  (gat_pin_i[c]),
      .ext_clk_i  (ext_clk_i),
      .tb_i       (tb_tick),
      .prev_i     (prev_src),
      .two_back_i (two_back_src),
      .pat_i      (pat_present_i),
      .occ_i      (pat_occ),
      .gone_i     (pat_gone),
      .clk_o      (clk_o[c]),
      .gate_o     (gate_o[c]),
      .clk_oe_o   (clk_pin_oe_o[c]),
      .gat_oe_o   (gat_pin_oe_o[c])
    );
  end
endmodule

// File: rtl/ctr_route_chk.sv
module ctr_route_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] clk_o,
  input logic [2:0] gate_o,
  input logic [2:0] clk_pin_oe_o,
  input logic [2:0] gat_pin_oe_o,
  input logic [2:0] clk_pin_i,
  input logic [2:0] gat_pin_i,
  input logic       pat_present_i,
  input logic       occ,
  input logic       gone,
  input logic       clr,
  input logic       tick0
);
  for (genvar c = 0; c < 3; c++) begin : g_ch
    // R12: a clock pin left as input must be what the counter sees
    p_clk_in_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clk_pin_oe_o[c] |-> clk_o[c] == clk_pin_i[c]);
    // R12: a gate pin left as input must be what the counter sees
    p_gat_in_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gat_pin_oe_o[c] |-> gate_o[c] == gat_pin_i[c]);
  end

  p_occ_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_present_i && !clr |=> occ);
  p_occ_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ && !clr |=> occ);
  p_gone_after_occ_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gone |-> occ);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !occ && !gone);
  p_tick_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick0 |=> !tick0);
endmodule

bind ctr_route ctr_route_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_o(clk_o), .gate_o(gate_o),
  .clk_pin_oe_o(clk_pin_oe_o), .gat_pin_oe_o(gat_pin_oe_o),
  .clk_pin_i(clk_pin_i), .gat_pin_i(gat_pin_i),
  .pat_present_i(pat_present_i), .occ(pat_occ), .gone(pat_gone),
  .clr(lat_clr), .tick0(tb_tick[0])
);

// File: tb/ctr_route_test.sv
module ctr_route_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_ch = '0;
  logic       wr_fld = 1'b0;
  logic [4:0] wr_data = '0;
  logic [2:0] clk_pin = '0, gat_pin = '0, ctr_out = '0, prev_out = '0;
  logic       ext_clk = 1'b0, pat = 1'b0;
  logic [2:0] clk_o, gate_o, cko, gto;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {string tag; int kind; int ch; int exp; int meas;} item_t;
  item_t sbq[$];
  event pushed;

  always #5 clk = ~clk;

  ctr_route uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_fld_i(wr_fld), .wr_data_i(wr_data), .clk_pin_i(clk_pin),
    .gat_pin_i(gat_pin), .ext_clk_i(ext_clk), .ctr_out_i(ctr_out),
    .prev_out_i(prev_out), .pat_present_i(pat), .clk_o(clk_o),
    .gate_o(gate_o), .clk_pin_oe_o(cko), .gat_pin_oe_o(gto)
  );

  function automatic int read_out(int kind);
    case (kind)
      0: return int'(clk_o);
      1: return int'(gate_o);
      2: return int'(cko);
      default: return int'(gto);
    endcase
  endfunction

  // monitor: pops expected items and compares with the design
  initial begin
    forever begin
      @(pushed);
      while (sbq.size() > 0) begin
        item_t it;
        int act;
        it = sbq.pop_front();
        act = (it.kind == 4) ? it.meas : read_out(it.kind);
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%0d expected=%0d", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_out(string tag, int kind, int exp);
    item_t it;
    it = '{tag, kind, 0, exp, 0};
    sbq.push_back(it);
    ->pushed;
    #1;
  endtask

  task automatic expect_meas(string tag, int meas, int exp);
    item_t it;
    it = '{tag, 4, 0, exp, meas};
    sbq.push_back(it);
    ->pushed;
    #1;
  endtask

  // write; returns at the negedge after the sampling edge
  task automatic wr(input logic [1:0] ch, input logic fld, input logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch; wr_fld = fld; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic set_all(input logic fld, input logic [4:0] d);
    for (int c = 0; c < 3; c++) wr(2'(c), fld, d);
  endtask

  task automatic count_pulses(input int ch, input int window, output int n);
    n = 0;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      #1;
      if (clk_o[ch]) n++;
    end
  endtask

  task automatic finish_run();
    #2;
    ->pushed;
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clk_pin = 3'b101;
    #1;
    // R1 reset state
    expect_out("R1 clk_o from pins", 0, 5);
    expect_out("R1 gate_o high", 1, 7);
    expect_out("R1 clk pin oe", 2, 0);
    expect_out("R1 gate pin oe", 3, 7);

    // R2 R12 shared ext clock and fixed levels
    wr(2'd1, 1'b0, 5'd7);
    ext_clk = 1'b1; #1;
    expect_out("R2 ext clock high", 0, 3'b111);
    ext_clk = 1'b0; #1;
    expect_out("R2 ext clock low", 0, 3'b101);
    expect_out("R12 clk oe on ch1", 2, 3'b010);
    wr(2'd2, 1'b0, 5'd8);
    expect_out("R2 constant high", 0, 3'b101);
    clk_pin = 3'b000; #1;
    expect_out("R2 high with pins low", 0, 3'b100);
    wr(2'd2, 1'b0, 5'd9);
    expect_out("R2 constant low", 0, 3'b000);

    // R11 unused codes
    wr(2'd2, 1'b0, 5'd12);
    expect_out("R11 clock code 12", 0, 0);
    wr(2'd2, 1'b0, 5'd31);
    expect_out("R11 clock code 31", 0, 0);
    wr(2'd2, 1'b1, 5'd4);
    expect_out("R11 gate code 4", 1, 3'b011);
    wr(2'd2, 1'b1, 5'd14);
    expect_out("R11 gate code 14", 1, 3'b011);

    // R4 preceding-channel clock with ring
    set_all(1'b0, 5'd6);
    prev_out = 3'b100; ctr_out = 3'b000; #1;
    expect_out("R4 ch0 from prev group ch2", 0, 3'b001);
    prev_out = 3'b000; ctr_out = 3'b011; #1;
    expect_out("R4 ch1/ch2 from own group", 0, 3'b110);
    ctr_out = 3'b100; #1;
    expect_out("R4 own ch2 unused", 0, 3'b000);

    // R5 R12 gate levels and pins
    wr(2'd0, 1'b1, 5'd0);
    wr(2'd1, 1'b1, 5'd1);
    wr(2'd2, 1'b1, 5'd2);
    gat_pin = 3'b100; #1;
    expect_out("R5 on/off/pin high", 1, 3'b101);
    expect_out("R12 gate oe off for pin", 3, 3'b011);
    gat_pin = 3'b000; #1;
    expect_out("R5 pin low", 1, 3'b001);
    wr(2'd2, 1'b1, 5'd6);
    expect_out("R5 inverted pin", 1, 3'b101);

    // R6 two-back gates
    set_all(1'b1, 5'd3);
    prev_out = 3'b010; ctr_out = 3'b000; #1;
    expect_out("R6 inverted two back", 1, 3'b110);
    set_all(1'b1, 5'd7);
    expect_out("R6 plain two back", 1, 3'b001);
    prev_out = 3'b100; ctr_out = 3'b001; #1;
    expect_out("R6 plain two back ring", 1, 3'b110);

    // R13 write isolation and timing
    prev_out = 3'b000; ctr_out = 3'b000; #1;
    expect_out("R13 baseline", 1, 3'b000);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'd1; wr_fld = 1'b1; wr_data = 5'd0;
    #1;
    expect_out("R13 no change before edge", 1, 3'b000);
    @(negedge clk);
    wr_en = 1'b0; #1;
    expect_out("R13 only ch1 gate updated", 1, 3'b010);
    expect_out("R13 clocks untouched", 2, 3'b111);

    // R3 timebases on ch0
    wr(2'd0, 1'b0, 5'd1); count_pulses(0, 200, n);
    expect_meas("R3 10 MHz pulses", n, 100);
    wr(2'd0, 1'b0, 5'd2); count_pulses(0, 200, n);
    expect_meas("R3 1 MHz pulses", n, 10);
    wr(2'd0, 1'b0, 5'd3); count_pulses(0, 2000, n);
    expect_meas("R3 100 kHz pulses", n, 10);
    wr(2'd0, 1'b0, 5'd4); count_pulses(0, 20000, n);
    expect_meas("R3 10 kHz pulses", n, 10);
    wr(2'd0, 1'b0, 5'd5); count_pulses(0, 40000, n);
    expect_meas("R3 1 kHz pulses", n, 2);
    wr(2'd0, 1'b0, 5'd11); count_pulses(0, 50, n);
    expect_meas("R3 20 MHz pulses", n, 50);

    // R7 R8 R9 pattern sources
    wr(2'd0, 1'b1, 5'd9);
    wr(2'd1, 1'b1, 5'd10);
    wr(2'd2, 1'b1, 5'd8);
    expect_out("R9 no gone before occurrence", 1, 3'b000);
    @(negedge clk); pat = 1'b1; #1;
    expect_out("R7 pattern present", 1, 3'b100);
    @(negedge clk); #1;
    expect_out("R8 occurred latch set", 1, 3'b101);
    pat = 1'b0; #1;
    expect_out("R7 pattern dropped", 1, 3'b001);
    @(negedge clk); #1;
    expect_out("R9 gone latch set", 1, 3'b011);
    repeat (3) @(negedge clk);
    #1;
    expect_out("R8 R9 latches hold", 1, 3'b011);
    wr(2'd0, 1'b1, 5'd12);
    wr(2'd1, 1'b1, 5'd13);
    wr(2'd2, 1'b1, 5'd11);
    expect_out("R7 R8 R9 inverted forms", 1, 3'b100);

    // R10 clear control
    wr(2'd3, 1'b0, 5'd0);
    expect_out("R10 clear bit zero ignored", 1, 3'b100);
    wr(2'd3, 1'b0, 5'd1);
    expect_out("R10 latches cleared", 1, 3'b111);
    repeat (4) @(negedge clk);
    #1;
    expect_out("R9 stays clear without pattern", 1, 3'b111);

    done = 1;
    finish_run();
  end
endmodule